// File: doc/BRIEF.md
# Red Ball Bounding Box Finder

This block watches a raster stream of already-filtered pixel class codes, one pixel per valid cycle with its column and row coordinates, a marker on the last pixel of each row and a frame-start strobe. It grows a bounding box over the red pixels of consecutive rows. Red pixels far to the side of the box are treated as noise, and the box is dropped when a run of red rows ends.

At each row end the block measures the box. If the box is at least as wide and as tall as two configuration inputs ask, it reports the box with a found flag. A reported box stays on the outputs until a later detection replaces it or a new frame starts. While nothing has been found, the outputs carry a minimum greater than the maximum, so a consumer can spot the empty case without reading the flag.

Top module: `red_ball_box`

## Requirements
- R1: After reset, `ball_found` is 0, both minimum outputs are all ones and both maximum outputs are 0.
- R2: A valid pixel is red when `pix_class` equals parameter RED_CLASS (default 1). The column extent changes only on the second of two consecutive valid red pixels within one row, using that second pixel's column. A lone red pixel changes nothing.
- R3: Once the box holds an extent, a red pair whose column lies more than NOISE_DIST (default 50) below the minimum or above the maximum is ignored. It neither widens the box nor marks the row as red.
- R4: The first red pair after a reset, a frame start or the end of a red run sets both column bounds to its column, with no distance check.
- R5: A row is red when it holds an accepted pair. Each red row sets the row maximum to its row number. The first red row after a non-red row also sets the row minimum.
- R6: On the last pixel of a row, the box is found when width (max x - min x + 1) is at least `min_width` and height (max y - min y + 1) is at least `min_height`. Both must hold, and the row must be red. The outputs show the box from the clock edge that samples that pixel.
- R7: A row with no accepted pair that follows a red row clears the box. The next pair then starts a fresh extent.
- R8: The outputs change only at a row-end pixel that makes a detection, at a frame start, or at reset. Otherwise they hold their values, including the last found box.
- R9: `frame_start` clears all tracking and returns the outputs to the R1 state on the next edge. Any pixel presented in the same cycle is ignored.
- R10: Whenever `ball_found` is 0, each reported minimum is greater than the matching maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Start of a new frame; clears all state |
| pix_valid | input | 1 | Pixel strobe |
| pix_class | input | CLS_W | Filtered class code of the pixel |
| pix_x | input | X_W | Column of the pixel |
| pix_y | input | Y_W | Row of the pixel |
| row_end | input | 1 | Marks the last pixel of a row |
| min_width | input | X_W | Smallest accepted box width |
| min_height | input | Y_W | Smallest accepted box height |
| ball_found | output | 1 | A box of sufficient size is reported |
| box_x_lo | output | X_W | Reported minimum column |
| box_x_hi | output | X_W | Reported maximum column |
| box_y_lo | output | Y_W | Reported minimum row |
| box_y_hi | output | Y_W | Reported maximum row |

## Verification
The only result the block produces is the reported box. It appears on the first edge after the row-end pixel that completes a detection, and on the first edge after a frame-start strobe. Every other edge must leave the outputs unchanged.

The bench drives each pixel just after a falling edge. It advances its behavioural model by that pixel at the same moment, and compares all five outputs with the model at the next falling edge, one rising edge later. This puts the comparison exactly one register stage behind the stimulus.

The sequences include:
- a noise pair beside a blob;
- lone red pixels;
- a blob that is only accepted if the run-end clear took place;
- width and height exactly at and just under the thresholds;
- a frame start with a red pixel in the same cycle.

// File: rtl/bbf_pkg.sv
package bbf_pkg;

   // What an incoming pixel does to the column extent
   typedef enum logic [1:0] {
      PX_NONE  = 2'd0,  // not the second pixel of a red pair
      PX_INIT  = 2'd1,  // first pair since the box was cleared
      PX_GROW  = 2'd2,  // pair inside the noise window
      PX_NOISE = 2'd3   // pair rejected as noise
   } px_evt_e;

endpackage

// File: rtl/bbf_pair_gate.sv
module bbf_pair_gate
   import bbf_pkg::*;
#(
   parameter int X_W        = 10,
   parameter int CLS_W      = 4,
   parameter int RED_CLASS  = 1,
   parameter int NOISE_DIST = 50,
   parameter bit NOISE_EN   = 1'b1
) (
   input  logic             pix_valid,
   input  logic [CLS_W-1:0] pix_class,
   input  logic [X_W-1:0]   pix_x,
   input  logic             prev_red,
   input  logic             box_init,
   input  logic [X_W-1:0]   xmin,
   input  logic [X_W-1:0]   xmax,
   output logic             is_red,
   output px_evt_e          evt
);

   localparam int XE_W = X_W + 1;
   localparam logic [XE_W-1:0] DIST = XE_W'(NOISE_DIST);
   localparam logic [CLS_W-1:0] RED = CLS_W'(RED_CLASS);

   logic near;
   logic pair;

   assign is_red = pix_valid && (pix_class == RED);
   assign pair   = is_red && prev_red;

   generate
      if (NOISE_EN) begin : g_gate
         logic [XE_W-1:0] xe;
         assign xe   = {1'b0, pix_x};
         assign near = ((xe + DIST) >= {1'b0, xmin}) &&
                       (xe <= ({1'b0, xmax} + DIST));
      end else begin : g_open
         assign near = 1'b1;
      end
   endgenerate

   always_comb begin
      if (!pair)          evt = PX_NONE;
      else if (!box_init) evt = PX_INIT;
      else if (near)      evt = PX_GROW;
      else                evt = PX_NOISE;
   end

endmodule

// File: rtl/bbf_extent.sv
module bbf_extent
   import bbf_pkg::*;
#(
   parameter int X_W = 10,
   parameter int Y_W = 9
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           pix_valid,
   input  logic           row_end,
   input  logic [X_W-1:0] pix_x,
   input  logic [Y_W-1:0] pix_y,
   input  logic           is_red,
   input  px_evt_e        evt,
   output logic           prev_red,
   output logic           box_init,
   output logic [X_W-1:0] xmin,
   output logic [X_W-1:0] xmax,
   output logic           row_done,
   output logic           row_red_now,
   output logic [X_W-1:0] nx_xlo,
   output logic [X_W-1:0] nx_xhi,
   output logic [Y_W-1:0] nx_ylo,
   output logic [Y_W-1:0] nx_yhi
);

   localparam logic [X_W-1:0] X_ONES = '1;
   localparam logic [Y_W-1:0] Y_ONES = '1;

   logic           row_red;
   logic           prev_row_red;
   logic [Y_W-1:0] ymin;
   logic [Y_W-1:0] ymax;
   logic           accepted;

   assign accepted    = (evt == PX_INIT) || (evt == PX_GROW);
   assign row_red_now = row_red || accepted;
   assign row_done    = pix_valid && row_end && !clear;

   always_comb begin
      nx_xlo = xmin;
      nx_xhi = xmax;
      if (evt == PX_INIT) begin
         nx_xlo = pix_x;
         nx_xhi = pix_x;
      end else if (evt == PX_GROW) begin
         if (pix_x < xmin) nx_xlo = pix_x;
         if (pix_x > xmax) nx_xhi = pix_x;
      end
      nx_yhi = pix_y;
      nx_ylo = prev_row_red ? ymin : pix_y;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_red     <= 1'b0;
         box_init     <= 1'b0;
         row_red      <= 1'b0;
         prev_row_red <= 1'b0;
         xmin         <= X_ONES;
         xmax         <= '0;
         ymin         <= Y_ONES;
         ymax         <= '0;
      end else if (clear) begin
         prev_red     <= 1'b0;
         box_init     <= 1'b0;
         row_red      <= 1'b0;
         prev_row_red <= 1'b0;
         xmin         <= X_ONES;
         xmax         <= '0;
         ymin         <= Y_ONES;
         ymax         <= '0;
      end else if (row_done) begin
         prev_red <= 1'b0;
         row_red  <= 1'b0;
         if (row_red_now) begin
            box_init     <= 1'b1;
            prev_row_red <= 1'b1;
            xmin         <= nx_xlo;
            xmax         <= nx_xhi;
            ymin         <= nx_ylo;
            ymax         <= nx_yhi;
         end else begin
            prev_row_red <= 1'b0;
            if (prev_row_red) begin
               box_init <= 1'b0;
               xmin     <= X_ONES;
               xmax     <= '0;
               ymin     <= Y_ONES;
               ymax     <= '0;
            end
         end
      end else if (pix_valid) begin
         prev_red <= is_red;
         row_red  <= row_red_now;
         xmin     <= nx_xlo;
         xmax     <= nx_xhi;
         if (evt == PX_INIT) box_init <= 1'b1;
      end
   end

endmodule

// File: rtl/bbf_decide.sv
module bbf_decide #(
   parameter int X_W = 10,
   parameter int Y_W = 9
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           row_done,
   input  logic           row_red_now,
   input  logic [X_W-1:0] nx_xlo,
   input  logic [X_W-1:0] nx_xhi,
   input  logic [Y_W-1:0] nx_ylo,
   input  logic [Y_W-1:0] nx_yhi,
   input  logic [X_W-1:0] min_width,
   input  logic [Y_W-1:0] min_height,
   output logic           found,
   output logic [X_W-1:0] x_lo,
   output logic [X_W-1:0] x_hi,
   output logic [Y_W-1:0] y_lo,
   output logic [Y_W-1:0] y_hi
);

   localparam int XE_W = X_W + 1;
   localparam int YE_W = Y_W + 1;

   logic [XE_W-1:0] width;
   logic [YE_W-1:0] height;
   logic            hit;

   assign width  = {1'b0, nx_xhi} - {1'b0, nx_xlo} + XE_W'(1);
   assign height = {1'b0, nx_yhi} - {1'b0, nx_ylo} + YE_W'(1);
   assign hit    = row_done && row_red_now &&
                   (width  >= {1'b0, min_width}) &&
                   (height >= {1'b0, min_height});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         found <= 1'b0;
         x_lo  <= '1;
         x_hi  <= '0;
         y_lo  <= '1;
         y_hi  <= '0;
      end else if (clear) begin
         found <= 1'b0;
         x_lo  <= '1;
         x_hi  <= '0;
         y_lo  <= '1;
         y_hi  <= '0;
      end else if (hit) begin
         found <= 1'b1;
         x_lo  <= nx_xlo;
         x_hi  <= nx_xhi;
         y_lo  <= nx_ylo;
         y_hi  <= nx_yhi;
      end
   end

endmodule

// File: rtl/red_ball_box.sv
module red_ball_box
   import bbf_pkg::*;
#(
   parameter int X_W        = 10,
   parameter int Y_W        = 9,
   parameter int CLS_W      = 4,
   parameter int RED_CLASS  = 1,
   parameter int NOISE_DIST = 50,
   parameter bit NOISE_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             pix_valid,
   input  logic [CLS_W-1:0] pix_class,
   input  logic [X_W-1:0]   pix_x,
   input  logic [Y_W-1:0]   pix_y,
   input  logic             row_end,
   input  logic [X_W-1:0]   min_width,
   input  logic [Y_W-1:0]   min_height,
   output logic             ball_found,
   output logic [X_W-1:0]   box_x_lo,
   output logic [X_W-1:0]   box_x_hi,
   output logic [Y_W-1:0]   box_y_lo,
   output logic [Y_W-1:0]   box_y_hi
);

   generate
      if (X_W < 2 || Y_W < 2 || CLS_W < 1)
         $error("red_ball_box: coordinate or class width too small");
      if (RED_CLASS >= (1 << CLS_W))
         $error("red_ball_box: RED_CLASS does not fit CLS_W");
      if (NOISE_DIST < 0 || NOISE_DIST >= (1 << X_W))
         $error("red_ball_box: NOISE_DIST out of range");
   endgenerate

   logic           is_red;
   px_evt_e        evt;
   logic           prev_red;
   logic           box_init;
   logic [X_W-1:0] xmin;
   logic [X_W-1:0] xmax;
   logic           row_done;
   logic           row_red_now;
   logic [X_W-1:0] nx_xlo;
   logic [X_W-1:0] nx_xhi;
   logic [Y_W-1:0] nx_ylo;
   logic [Y_W-1:0] nx_yhi;

   bbf_pair_gate #(
      .X_W(X_W), .CLS_W(CLS_W), .RED_CLASS(RED_CLASS),
      .NOISE_DIST(NOISE_DIST), .NOISE_EN(NOISE_EN)
   ) i_gate (
      .pix_valid(pix_valid && !frame_start),
      .pix_class(pix_class),
      .pix_x    (pix_x),
      .prev_red (prev_red),
      .box_init (box_init),
      .xmin     (xmin),
      .xmax     (xmax),
      .is_red   (is_red),
      .evt      (evt)
   );

   bbf_extent #(.X_W(X_W), .Y_W(Y_W)) i_extent (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (frame_start),
      .pix_valid  (pix_valid),
      .row_end    (row_end),
      .pix_x      (pix_x),
      .pix_y      (pix_y),
      .is_red     (is_red),
      .evt        (evt),
      .prev_red   (prev_red),
      .box_init   (box_init),
      .xmin       (xmin),
      .xmax       (xmax),
      .row_done   (row_done),
      .row_red_now(row_red_now),
      .nx_xlo     (nx_xlo),
      .nx_xhi     (nx_xhi),
      .nx_ylo     (nx_ylo),
      .nx_yhi     (nx_yhi)
   );

   bbf_decide #(.X_W(X_W), .Y_W(Y_W)) i_decide (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (frame_start),
      .row_done   (row_done),
      .row_red_now(row_red_now),
      .nx_xlo     (nx_xlo),
      .nx_xhi     (nx_xhi),
      .nx_ylo     (nx_ylo),
      .nx_yhi     (nx_yhi),
      .min_width  (min_width),
      .min_height (min_height),
      .found      (ball_found),
      .x_lo       (box_x_lo),
      .x_hi       (box_x_hi),
      .y_lo       (box_y_lo),
      .y_hi       (box_y_hi)
   );

endmodule

// File: rtl/red_ball_box_chk.sv
module red_ball_box_chk #(
   parameter int X_W = 10,
   parameter int Y_W = 9
) (
   input logic           clk,
   input logic           rst_n,
   input logic           frame_start,
   input logic           pix_valid,
   input logic           row_end,
   input logic           ball_found,
   input logic [X_W-1:0] box_x_lo,
   input logic [X_W-1:0] box_x_hi,
   input logic [Y_W-1:0] box_y_lo,
   input logic [Y_W-1:0] box_y_hi
);

   // R10
   empty_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ball_found |-> (box_x_lo > box_x_hi) && (box_y_lo > box_y_hi));

   // R6
   found_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ball_found |-> (box_x_lo <= box_x_hi) && (box_y_lo <= box_y_hi));

   // R6
   found_at_row_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ball_found) |-> $past(pix_valid && row_end));

   // R8
   hold_between_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(pix_valid && row_end) && !frame_start) |=>
         ($stable(ball_found) && $stable(box_x_lo) && $stable(box_x_hi) &&
          $stable(box_y_lo) && $stable(box_y_hi)));

   // R9
   frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !ball_found);

endmodule

bind red_ball_box red_ball_box_chk #(.X_W(X_W), .Y_W(Y_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_start(frame_start),
   .pix_valid  (pix_valid),
   .row_end    (row_end),
   .ball_found (ball_found),
   .box_x_lo   (box_x_lo),
   .box_x_hi   (box_x_hi),
   .box_y_lo   (box_y_lo),
   .box_y_hi   (box_y_hi)
);

// File: tb/test_red_ball_box.sv
`timescale 1ns/100ps
module test_red_ball_box;

   localparam int X_W = 10;
   localparam int Y_W = 9;
   localparam int CLS_W = 4;
   localparam int ROW_LEN = 100;
   localparam int DIST = 50;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             frame_start = 1'b0;
   logic             pix_valid = 1'b0;
   logic [CLS_W-1:0] pix_class = '0;
   logic [X_W-1:0]   pix_x = '0;
   logic [Y_W-1:0]   pix_y = '0;
   logic             row_end = 1'b0;
   logic [X_W-1:0]   min_width = X_W'(8);
   logic [Y_W-1:0]   min_height = Y_W'(3);
   logic             ball_found;
   logic [X_W-1:0]   box_x_lo;
   logic [X_W-1:0]   box_x_hi;
   logic [Y_W-1:0]   box_y_lo;
   logic [Y_W-1:0]   box_y_hi;

   always #2.5 clk = ~clk;

   red_ball_box i_red_ball_box (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .pix_valid(pix_valid), .pix_class(pix_class), .pix_x(pix_x),
      .pix_y(pix_y), .row_end(row_end), .min_width(min_width),
      .min_height(min_height), .ball_found(ball_found),
      .box_x_lo(box_x_lo), .box_x_hi(box_x_hi),
      .box_y_lo(box_y_lo), .box_y_hi(box_y_hi)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   string tag = "R1";

   // behavioural model state
   int m_prev_red, m_init, m_xlo, m_xhi, m_ylo, m_yhi, m_rowred, m_prevrow;
   int e_found, e_xlo, e_xhi, e_ylo, e_yhi;

   task automatic model_clear();
      m_prev_red = 0; m_init = 0; m_rowred = 0; m_prevrow = 0;
      m_xlo = 0; m_xhi = 0; m_ylo = 0; m_yhi = 0;
      e_found = 0; e_xlo = (1 << X_W) - 1; e_xhi = 0;
      e_ylo = (1 << Y_W) - 1; e_yhi = 0;
   endtask

   task automatic model_pixel(int fs, int v, int cls, int x, int y, int re);
      int red, acc, rowred, w, h;
      if (fs != 0) begin
         model_clear();
         return;
      end
      if (v == 0) return;
      red = (cls == 1);
      acc = 0;
      if (red != 0 && m_prev_red != 0) begin
         if (m_init == 0) begin
            m_xlo = x; m_xhi = x; m_init = 1; acc = 1;
         end else if (x >= m_xlo - DIST && x <= m_xhi + DIST) begin
            if (x < m_xlo) m_xlo = x;
            if (x > m_xhi) m_xhi = x;
            acc = 1;
         end
      end
      rowred = (m_rowred != 0 || acc != 0);
      if (re != 0) begin
         if (rowred != 0) begin
            m_yhi = y;
            if (m_prevrow == 0) m_ylo = y;
            w = m_xhi - m_xlo + 1;
            h = m_yhi - m_ylo + 1;
            if (w >= int'(min_width) && h >= int'(min_height)) begin
               e_found = 1; e_xlo = m_xlo; e_xhi = m_xhi;
               e_ylo = m_ylo; e_yhi = m_yhi;
            end
            m_prevrow = 1;
         end else begin
            if (m_prevrow != 0) m_init = 0;
            m_prevrow = 0;
         end
         m_rowred = 0;
         m_prev_red = 0;
      end else begin
         m_prev_red = red;
         m_rowred = rowred;
      end
   endtask

   task automatic compare();
      n_chk++;
      if (int'(ball_found) != e_found || int'(box_x_lo) != e_xlo ||
          int'(box_x_hi) != e_xhi || int'(box_y_lo) != e_ylo ||
          int'(box_y_hi) != e_yhi) begin
         n_bad++;
         $display("FAIL %s t=%0t actual found=%0d x=%0d..%0d y=%0d..%0d expected found=%0d x=%0d..%0d y=%0d..%0d",
                  tag, $time, ball_found, box_x_lo, box_x_hi, box_y_lo, box_y_hi,
                  e_found, e_xlo, e_xhi, e_ylo, e_yhi);
      end
   endtask

   task automatic step(int fs, int v, int cls, int x, int y, int re);
      @(negedge clk);
      compare();
      frame_start = (fs != 0);
      pix_valid   = (v != 0);
      pix_class   = CLS_W'(cls);
      pix_x       = X_W'(x);
      pix_y       = Y_W'(y);
      row_end     = (re != 0);
      model_pixel(fs, v, cls, x, y, re);
   endtask

   // red on columns lo..hi (none when hi < lo), plus a red pair at nx, nx+1
   task automatic send_row(int y, int lo, int hi, int nx);
      for (int x = 0; x < ROW_LEN; x++) begin
         int c;
         c = ((x >= lo && x <= hi) || (nx >= 0 && (x == nx || x == nx + 1))) ? 1 : 2;
         step(0, 1, c, x, y, (x == ROW_LEN - 1) ? 1 : 0);
      end
      step(0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      // R1: reset state
      tag = "R1";
      compare();
      rst_n = 1'b1;
      step(0, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0, 0);
      tag = "R5 R10";
      send_row(0, 1, 0, -1);
      send_row(1, 1, 0, -1);
      // R4 R5 R6: blob x 11..20, noise pair at 80/81 rejected (R3)
      tag = "R4 R5";
      send_row(2, 10, 20, -1);
      tag = "R3";
      send_row(3, 10, 20, 80);
      tag = "R6";
      send_row(4, 10, 20, -1);
      send_row(5, 10, 20, -1);
      // R7: run ends, box cleared, output held
      tag = "R7 R8";
      send_row(6, 1, 0, -1);
      // R2: lone red pixels change nothing
      tag = "R2";
      send_row(7, 40, 40, -1);
      send_row(8, 40, 40, -1);
      send_row(9, 40, 40, -1);
      // R4 R7: blob far from the old box only counts after the clear
      tag = "R4 R7";
      send_row(10, 85, 99, -1);
      send_row(11, 85, 99, -1);
      send_row(12, 85, 99, -1);
      send_row(13, 1, 0, -1);
      // R6 R8: width 7 misses threshold 8, old box held
      tag = "R6 R8";
      send_row(14, 30, 37, -1);
      send_row(15, 30, 37, -1);
      send_row(16, 30, 37, -1);
      send_row(17, 1, 0, -1);
      // R6: width 8 and height 3 exactly meet thresholds
      tag = "R6";
      send_row(18, 30, 38, -1);
      send_row(19, 30, 38, -1);
      send_row(20, 30, 38, -1);
      // R9: frame start with a red row-end pixel in the same cycle
      tag = "R9 R10";
      step(0, 1, 1, 50, 21, 0);
      step(1, 1, 1, 51, 21, 1);
      step(0, 0, 0, 0, 0, 0);
      send_row(0, 5, 30, -1);
      step(0, 0, 0, 0, 0, 0);
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule